// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills a whole connection memory from hardware in one pass, so software does not have to write every location itself. Software first sets an allow bit in a control register. It then sets a start bit in a mode register. At the next frame boundary the sequencer walks the memory from location 0 upwards, one word per clock. Every word receives a 5-bit control pattern in bits 15:11 and zeros in bits 10:0. The pattern comes from bits 9:5 of the mode register. When the last word has been written, the start bit clears itself.

The memory has a single write port. The processor's bus shares it with the fill sequencer. While a fill is pending or running, processor writes to the memory and to the mode register are dropped. Clearing the allow bit cancels a pending or running fill at once. Reads through the bus always return the value currently stored. The memory holds 4 streams of 32 channels, which is 128 words. Because the sequencer needs only 128 clocks after the first frame pulse, the fill ends within two frames.

Top module: `cmem_fill_top`

## Requirements
- R1: After reset, the control register reads 0 and the mode register reads 0. Both are reached with bus_addr[7]=0: offset 0 is the control register and offset 1 is the mode register.
- R2: The control register keeps bit 0 (the allow bit) and reads all its other bits as 0. While no fill is pending, the mode register keeps every written bit, subject to R3.
- R3: Bit 4 of the mode register (the start bit) can be set only while the allow bit is 1. A mode write made while the allow bit is 0 stores the other bits and leaves bit 4 at 0.
- R4: After the start bit is set, the memory is not changed until the first clock on which frame_sync is sampled high.
- R5: Starting with the first clock after that frame_sync, the sequencer writes locations 0, 1, … DEPTH-1 on successive clocks. Each location receives {mode[9:5], 11'b0}.
- R6: The start bit reads 0 from the clock after the last location is written. A mode read whose capturing edge falls one clock after the frame_sync edge is counted as poll 1; the first poll that shows the start bit as 0 is poll DEPTH+1.
- R7: A processor write to the memory (bus_addr[7]=1, word index in bus_addr[6:0]) is dropped while the start bit is 1. At any other time it is stored.
- R8: Writing 0 to the allow bit while a fill is pending or running clears the start bit in the same clock and stops the fill. Locations already written keep the pattern, and all the others keep their earlier contents.
- R9: When bus_rd is high, bus_rdata holds the addressed register or memory word from the following clock on.
- R10: A write to the mode register is dropped while the start bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame boundary pulse, one clock wide |
| bus_addr | input | 8 | Bit 7 selects the memory (1) or the registers (0); the lower bits give the word or register offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that bus_wr and bus_rd are each one clock wide. They also assume that frame_sync is a single-clock pulse, and that the frame period is longer than DEPTH clocks, so that no fill can straddle more than one boundary. The bench keeps to these limits: every strobe comes from a task that holds it for exactly one clock, and frame pulses are issued only by a dedicated task, never closer together than a full fill. Inputs change only on falling edges, which lets the exact write window of the sequencer be counted edge by edge.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
    localparam int CM_WORD_W  = 16;
    localparam int PAT_W      = 5;
    localparam int PAT_LSB    = 5;
    localparam int START_BIT  = 4;
    localparam int ZERO_W     = CM_WORD_W - PAT_W;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_FILL  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                 allow;
        logic [CM_WORD_W-1:0] mode;
    } regs_t;
endpackage

// File: rtl/cmf_regs.sv
module cmf_regs
    import cmf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_mode,
    input  logic [CM_WORD_W-1:0] wdata,
    input  logic                 fill_done,
    output logic                 allow_q,
    output logic                 start_q,
    output logic [CM_WORD_W-1:0] mode_q
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.allow = wdata[0];
            if (!wdata[0]) begin
                r_d.mode[START_BIT] = 1'b0;
            end
        end
        if (wr_mode && !r_q.mode[START_BIT]) begin
            r_d.mode = wdata;
            if (!r_q.allow) begin
                r_d.mode[START_BIT] = 1'b0;
            end
        end
        if (fill_done) begin
            r_d.mode[START_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign allow_q = r_q.allow;
    assign start_q = r_q.mode[START_BIT];
    assign mode_q  = r_q.mode;

    AST_START_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> allow_q); // R3
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_q) && start_q) |-> (mode_q == $past(mode_q))); // R10
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !start_q); // R6
endmodule

// File: rtl/cmf_seq.sv
module cmf_seq
    import cmf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_q,
    input  logic          allow_q,
    input  logic          frame_sync,
    output logic          fill_we,
    output logic [AW-1:0] fill_addr,
    output logic          fill_done
);
    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        fill_we   = (s_q.state == SEQ_FILL) && start_q && allow_q;
        fill_done = fill_we && (s_q.cnt == AW'(DEPTH - 1));
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (start_q) begin
                    s_d.cnt   = '0;
                    s_d.state = frame_sync ? SEQ_FILL : SEQ_ARMED;
                end
            end
            SEQ_ARMED: begin
                if (!start_q) begin
                    s_d.state = SEQ_IDLE;
                end else if (frame_sync) begin
                    s_d.state = SEQ_FILL;
                    s_d.cnt   = '0;
                end
            end
            SEQ_FILL: begin
                if (!fill_we || fill_done) begin
                    s_d.state = SEQ_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: SEQ_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign fill_addr = s_q.cnt;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && $past(fill_we)) |-> (fill_addr == $past(fill_addr) + 1'b1)); // R5
    AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !$past(fill_we)) |-> (fill_addr == '0)); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |=> !fill_we); // R8
endmodule

// File: rtl/cmf_mem.sv
module cmf_mem #(
    parameter int DEPTH = 128,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cmem_fill_top.sv
module cmem_fill_top
    import cmf_pkg::*;
#(
    parameter int STREAMS = 4,
    parameter int SLOTS   = 32,
    localparam int DEPTH  = STREAMS * SLOTS,
    localparam int AW     = $clog2(DEPTH)
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_sync,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);
    logic                 is_mem;
    logic                 wr_ctrl, wr_mode, cpu_we;
    logic                 allow_q, start_q;
    logic [CM_WORD_W-1:0] mode_q;
    logic                 fill_we, fill_done;
    logic [AW-1:0]        fill_addr;
    logic                 mem_we;
    logic [AW-1:0]        mem_waddr;
    logic [CM_WORD_W-1:0] mem_wdata, mem_rdata;
    logic [CM_WORD_W-1:0] rdata_d, rdata_q;

    assign is_mem  = bus_addr[7];
    assign wr_ctrl = bus_wr && !is_mem && (bus_addr[6:0] == 7'd0);
    assign wr_mode = bus_wr && !is_mem && (bus_addr[6:0] == 7'd1);
    assign cpu_we  = bus_wr && is_mem && !start_q;

    cmf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_mode   (wr_mode),
        .wdata     (bus_wdata),
        .fill_done (fill_done),
        .allow_q   (allow_q),
        .start_q   (start_q),
        .mode_q    (mode_q)
    );

    cmf_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_q    (start_q),
        .allow_q    (allow_q),
        .frame_sync (frame_sync),
        .fill_we    (fill_we),
        .fill_addr  (fill_addr),
        .fill_done  (fill_done)
    );

    always_comb begin
        mem_we    = fill_we || cpu_we;
        mem_waddr = fill_we ? fill_addr : bus_addr[AW-1:0];
        mem_wdata = fill_we ? {mode_q[PAT_LSB +: PAT_W], {ZERO_W{1'b0}}} : bus_wdata;
    end

    cmf_mem #(.DEPTH(DEPTH), .W(CM_WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (bus_addr[AW-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            if (is_mem) begin
                rdata_d = mem_rdata;
            end else if (bus_addr[6:0] == 7'd0) begin
                rdata_d = {{(CM_WORD_W-1){1'b0}}, allow_q};
            end else if (bus_addr[6:0] == 7'd1) begin
                rdata_d = mode_q;
            end else begin
                rdata_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

    AST_FILL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_mem && fill_we) |=> start_q || !allow_q || $past(fill_done)); // R7
endmodule

// File: tb/cmem_fill_top_bench.sv
module cmem_fill_top_bench;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    cmem_fill_top u_cmem_fill_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_frame();
        frame_sync = 1'b1;
        @(posedge clk); @(negedge clk);
        frame_sync = 1'b0;
    endtask

    function automatic logic [15:0] prefill(input int a);
        return 16'((a << 4) | 7);
    endfunction

    task automatic load_prefill();
        for (int a = 0; a < DEPTH; a++) wr(8'h80 | 8'(a), prefill(a));
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] word;
        int polls;
        int j;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(8'h00, v); check(v == 16'h0, "R1 ctrl reset", v, 16'h0);
        rd(8'h01, v); check(v == 16'h0, "R1 mode reset", v, 16'h0);

        wr(8'h00, 16'hFFFF);
        rd(8'h00, v); check(v == 16'h0001, "R2 ctrl keeps bit0", v, 16'h0001);
        wr(8'h01, 16'hA3E5 & ~16'h0010);
        rd(8'h01, v); check(v == (16'hA3E5 & ~16'h0010), "R2 mode readback", v, 16'hA3E5 & ~16'h0010);

        wr(8'h00, 16'h0000);
        wr(8'h01, 16'h03F0);
        rd(8'h01, v); check(v == 16'h03E0, "R3 start blocked without allow", v, 16'h03E0);

        load_prefill();
        for (int a = 0; a < DEPTH; a++) begin
            rd(8'h80 | 8'(a), v);
            check(v == prefill(a), "R7 R9 cpu write stored", v, prefill(a));
        end

        for (int i = 0; i < 4; i++) begin
            logic [4:0] pat;
            logic [15:0] mword;
            pat = 5'((i * 13 + 5) & 31);
            mword = 16'({pat, 5'b10000});
            word = {pat, 11'b0};
            wr(8'h00, 16'h0001);
            wr(8'h01, mword);
            rd(8'h01, v); check(v == mword, "R3 start set with allow", v, mword);
            wr(8'h85, 16'h7777);
            wr(8'h01, 16'h0000);
            rd(8'h01, v); check(v == mword, "R10 mode write dropped", v, mword);
            repeat (10) @(negedge clk);
            rd(8'h80, v); check(v != word || word == 16'h0 && v == prefill(0) , "R4 no write before frame", v, prefill(0));
            rd(8'h85, v); check(v != 16'h7777, "R7 cpu write dropped while pending", v, 16'h0);
            pulse_frame();
            polls = 0;
            do begin
                rd(8'h01, v);
                polls++;
            end while (v[4] && polls < 2 * DEPTH);
            check(polls == DEPTH + 1, "R6 start clears after last write", 16'(polls), 16'(DEPTH + 1));
            for (int a = 0; a < DEPTH; a++) begin
                rd(8'h80 | 8'(a), v);
                check(v == word, "R5 filled word", v, word);
            end
            load_prefill();
        end

        wr(8'h00, 16'h0001);
        wr(8'h01, 16'h02B0);
        repeat (40) @(negedge clk);
        pulse_frame();
        repeat (40) @(negedge clk);
        wr(8'h00, 16'h0000);
        rd(8'h01, v); check(v[4] == 1'b0, "R8 start cleared on stop", v, 16'h02A0);
        j = -1;
        for (int a = 0; a < DEPTH; a++) begin
            rd(8'h80 | 8'(a), v);
            if (v == 16'hA800) begin
                check(j < 0, "R8 filled prefix contiguous", v, prefill(a));
            end else begin
                if (j < 0) j = a;
                check(v == prefill(a), "R8 untouched tail", v, prefill(a));
            end
        end
        check(j >= 38 && j <= 44, "R8 stop point", 16'(j), 16'd41);

        wr(8'h00, 16'h0001);
        wr(8'h01, 16'h0030);
        wr(8'h00, 16'h0000);
        pulse_frame();
        repeat (DEPTH + 4) @(negedge clk);
        rd(8'h80 | 8'(DEPTH - 1), v);
        check(v == prefill(DEPTH - 1), "R8 pending fill cancelled", v, prefill(DEPTH - 1));
        wr(8'h81, 16'h1234);
        rd(8'h81, v); check(v == 16'h1234, "R7 cpu write after stop", v, 16'h1234);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule